// File: doc/BRIEF.md
# Eight-Output Addressable Latch with Demultiplexer Mode

This block holds eight single-bit values and exposes them on an eight-bit output bus. A 3-bit address picks one bit position. A single serial data input supplies the value for that position. Two active-low controls, a write strobe and a clear strobe, together pick one of four modes:

- write the addressed bit;
- hold every bit;
- steer the data input to the addressed output as a one-of-eight demultiplexer;
- clear the whole block.

Storage is held in flip-flops on a system clock, so the block contains no inferred latches. In write mode the addressed bit takes the data input on each rising edge, and the outputs show the stored value. In demultiplexer mode the outputs are combinational from the address and data, and the stored bits are left untouched. Clear mode forces the outputs low at once and empties storage on the next edge. A separate synchronous active-high power-on reset also empties storage.

A typical use is to drive eight control lines one bit at a time from a narrow serial source. The same block can instead serve as a one-of-eight strobe decoder.

Top module: `addr_latch8`

## Requirements
- R1: Address value i selects output bit q[i]; no other output bit is affected by an address-directed operation.
- R2: Write mode (en_n=0, clr_n=1): on each rising edge the stored bit at the address takes din, and the other seven stored bits keep their values. The outputs show the stored bits.
- R3: Hold mode (en_n=1, clr_n=1): the outputs show the stored bits unchanged, whatever sel and din do.
- R4: Demultiplexer mode (en_n=0, clr_n=0): q[sel] equals din in the same cycle, without waiting for a clock edge, and every other output is 0.
- R5: Clear mode (en_n=1, clr_n=0): all outputs are 0 regardless of sel and din.
- R6: A rising edge in clear mode empties the stored bits, so a following hold mode shows all zeros.
- R7: Demultiplexer mode never modifies the stored bits; the hold mode that follows shows the values stored before it.
- R8: With por=1 at a rising edge, the stored bits become 0 in every mode, including write mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| por | input | 1 | Synchronous active-high power-on reset of the stored bits |
| en_n | input | 1 | Active-low write/steer strobe |
| clr_n | input | 1 | Active-low clear strobe |
| sel | input | AW (3) | Bit address |
| din | input | 1 | Serial data input |
| q | output | 2**AW (8) | Output bus |

## Verification
The assertions take for granted that sel and din are stable around each rising edge. They also assume that the address is never changed by more than one bit while the block is in write mode, since a multi-bit change there could briefly point at the wrong bit. The stimulus follows this rule. Every write is preceded by a hold-mode cycle that sets up the address, and the address stays the same across the write cycle. Addresses change freely only in hold, demultiplexer and clear modes, where no stored bit depends on them.

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 por,
  input  logic                 en_n,
  input  logic                 clr_n,
  input  logic [AW-1:0]        sel,
  input  logic                 din,
  output logic [(1<<AW)-1:0]   q
);
  localparam int N = 1 << AW;

  typedef enum logic [1:0] {M_WRITE, M_HOLD, M_STEER, M_CLEAR} mode_t;

  mode_t         mode;
  logic [N-1:0]  st;
  logic [N-1:0]  hot;

  assign mode = en_n ? (clr_n ? M_HOLD : M_CLEAR) : (clr_n ? M_WRITE : M_STEER);
  assign hot  = din ? (N'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (por) st <= '0;
    else begin
      case (mode)
        M_WRITE: st[sel] <= din;
        M_CLEAR: st <= '0;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (mode)
      M_STEER: q = hot;
      M_CLEAR: q = '0;
      default: q = st;
    endcase
  end
endmodule

module addr_latch8_chk #(
  parameter int AW = 3
) (
  input logic               clk,
  input logic               por,
  input logic               en_n,
  input logic               clr_n,
  input logic [AW-1:0]      sel,
  input logic               din,
  input logic [(1<<AW)-1:0] q
);
  // R5
  clear_low_chk: assert property (@(posedge clk) disable iff (por)
    (en_n && !clr_n) |-> (q == '0));

  // R4
  steer_onehot_chk: assert property (@(posedge clk) disable iff (por)
    (!en_n && !clr_n) |-> ($onehot0(q) && ((|q) == din) && (q[sel] == din)));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (por)
    (en_n && clr_n && $past(en_n && clr_n && !por)) |-> $stable(q));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (por)
    ($past(!en_n && clr_n && !por) && clr_n) |-> (q[$past(sel)] == $past(din)));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (por)
    ($past(en_n && !clr_n) && clr_n) |-> (q == '0));

  // R8
  por_empties_chk: assert property (@(posedge clk) disable iff (por)
    ($past(por) && clr_n) |-> (q == '0));
endmodule

bind addr_latch8 addr_latch8_chk #(.AW(AW)) u_chk (
  .clk(clk), .por(por), .en_n(en_n), .clr_n(clr_n),
  .sel(sel), .din(din), .q(q)
);

// File: tb/addr_latch8_tb.sv
`timescale 1ns/1ps
module addr_latch8_tb;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [2:0] sel = '0;
  logic       din = 1'b0;
  logic [7:0] q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit model_st [8];

  always #2.5 clk = ~clk;

  addr_latch8 u_dut (
    .clk(clk), .por(por), .en_n(en_n), .clr_n(clr_n),
    .sel(sel), .din(din), .q(q)
  );

  function automatic logic [7:0] expected();
    logic [7:0] e;
    for (int i = 0; i < 8; i++) begin
      if (!en_n && !clr_n)     e[i] = (int'(sel) == i) ? din : 1'b0;
      else if (en_n && !clr_n) e[i] = 1'b0;
      else                     e[i] = model_st[i];
    end
    return e;
  endfunction

  task automatic step(input bit p, input bit en, input bit cl,
                      input int a, input bit d, input string tag);
    logic [7:0] e;
    @(negedge clk);
    por = p; en_n = en; clr_n = cl; sel = 3'(a); din = d;
    #1;
    e = expected();
    checks++;
    if (q !== e) begin
      failures++;
      $display("FAIL %s: q=%b expected=%b (en_n=%b clr_n=%b sel=%0d din=%b)",
               tag, q, e, en, cl, a, d);
    end
    @(posedge clk);
    if (p) begin
      for (int i = 0; i < 8; i++) model_st[i] = 1'b0;
    end else if (!en && cl) begin
      model_st[a] = d;
    end else if (en && !cl) begin
      for (int i = 0; i < 8; i++) model_st[i] = 1'b0;
    end
  endtask

  task automatic write_bit(input int a, input bit d, input string tag);
    step(0, 1, 1, a, ~d, "R3");
    step(0, 0, 1, a, d, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model_st[i] = 1'b0;
    step(1, 1, 1, 0, 0, "R8");
    step(1, 1, 1, 5, 1, "R8");
    step(0, 1, 1, 2, 1, "R8");

    write_bit(0, 1, "R2");
    write_bit(3, 1, "R2");
    write_bit(5, 1, "R2");
    write_bit(7, 1, "R2");
    step(0, 1, 1, 7, 1, "R2");
    write_bit(3, 0, "R2");
    step(0, 0, 1, 3, 0, "R2");

    for (int i = 0; i < 8; i++) step(0, 1, 1, i, i % 2, "R3");

    for (int i = 0; i < 8; i++) step(0, 0, 0, i, 1, "R1");
    for (int i = 7; i >= 0; i--) step(0, 0, 0, i, 0, "R4");
    step(0, 0, 0, 6, 1, "R4");
    step(0, 1, 1, 6, 0, "R7");
    step(0, 1, 1, 1, 1, "R7");

    for (int i = 0; i < 4; i++) step(0, 1, 0, i * 2 + 1, 1, "R5");
    step(0, 1, 1, 0, 1, "R6");
    step(0, 1, 1, 7, 0, "R6");

    write_bit(2, 1, "R2");
    write_bit(6, 1, "R2");
    step(0, 1, 1, 6, 0, "R1");
    step(1, 0, 1, 6, 1, "R8");
    step(0, 1, 1, 4, 1, "R8");

    write_bit(4, 1, "R2");
    step(0, 0, 0, 1, 1, "R4");
    step(0, 1, 0, 4, 1, "R5");
    step(0, 0, 0, 4, 1, "R4");
    step(0, 1, 1, 4, 0, "R6");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule